// File: doc/BRIEF.md
# Serial Shift Port

A small hardware assistant for synchronous serial links whose framing is handled by software. An 8-bit shift register sends data out of its most significant bit and takes data in at its least significant bit. It shares one event clock with a 4-bit counter. That counter wraps from 15 to 0 to set an overflow flag, and the flag can drive an interrupt line. Software uses a register port to load and read the shift register, preset the counter, clear the flag and select the clock source.

Three sources can supply shift events: the serial clock pin, a one-cycle timer tick, or a strobe written by software. The serial clock pin and the serial data pin are synchronized into the system clock domain. When the pin is the source, one edge direction (selectable) shifts the register. The opposite edge opens a hold stage in front of the serial output, so the output changes half a serial period after sampling. In this mode the counter advances on every pin edge, so a full byte is 16 counts. There is no receive buffer: each shift overwrites the register in place.

Top module: `ser_shift_port`

## Requirements
- R1: After reset, every readable register reads 0, `irq` is low and `sdo_pin` is low.
- R2: Register map on `host_addr`. Address 0 is the data register (read/write). Address 1 is the counter in bits [3:0], and its upper bits read 0. Address 2 holds the overflow flag in bit 0. Address 3 is control: bits [1:0] select the source (0 none, 1 pin, 2 timer, 3 software), bit 2 makes the falling pin edge the sampling edge, and bit 3 enables the interrupt. Bit 4 is a write-only strobe that reads back as 0.
- R3: On each shift event the data register moves left one place, and the synchronized `sdi_pin` enters bit 0.
- R4: Every count event adds one to the counter. With the timer or software source, each event both counts and shifts. With the pin source, every pin edge counts, so eight bits give 16 counts.
- R5: With the pin source, only the sampling edge shifts: rising when control bit 2 is 0, falling when it is 1. A pin edge takes effect within four system clock cycles.
- R6: With the pin source, `sdo_pin` holds its value and takes the register MSB only on the non-sampling edge. With any other source, `sdo_pin` follows the register MSB.
- R7: A count event at 15 wraps the counter to 0 and sets the overflow flag. Writing 1 to status bit 0 clears the flag, but a wrap in the same cycle keeps it set.
- R8: `irq` is high exactly while the overflow flag and the interrupt enable are both set.
- R9: A host write to the data register or to the counter takes precedence over a shift or count event to that register in the same cycle.
- R10: Events from a source that is not selected are ignored. Source 0 produces no events.
- R11: The software strobe produces one event only when the software source is already selected when the strobe is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| sck_pin | input | 1 | External serial clock |
| sdi_pin | input | 1 | Serial data in |
| tmr_tick | input | 1 | One-cycle timer event |
| sdo_pin | output | 1 | Serial data out |
| irq | output | 1 | Overflow interrupt |

## Verification
Software strobes with alternating input bits show whether the right bit enters bit 0, and they confirm that the output follows the MSB at once. Timer ticks show that a wrap sets the flag, and they isolate the interrupt enable. Ticks issued in the same cycle as host writes separate write precedence from clear-versus-set precedence. Pin edges, driven separately for each sampling polarity, show that the counter counts edges and not bits, that only the sampling edge shifts, and that the output stays held until the opposite edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_PIN = 2'd1,
    SRC_TMR = 2'd2,
    SRC_SW  = 2'd3
  } ssp_src_e;

  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_COUNT = 2'd1,
    REG_STAT  = 2'd2,
    REG_CTRL  = 2'd3
  } ssp_reg_e;

  localparam int CTRL_FALL_BIT   = 2;
  localparam int CTRL_IEN_BIT    = 3;
  localparam int CTRL_STROBE_BIT = 4;
endpackage

// File: rtl/ssp_event_gen.sv
module ssp_event_gen
  import ssp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck_pin,
  input  logic     sdi_pin,
  input  logic     tmr_tick,
  input  logic     sw_strobe,
  input  ssp_src_e src,
  input  logic     smp_fall,
  output logic     sdi_s,
  output logic     shift_evt,
  output logic     cnt_evt,
  output logic     latch_open
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sck_sync;
  logic [TOP:0] sdi_sync;
  logic         sck_prev;
  logic         sck_rise;
  logic         sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync <= '0;
      sdi_sync <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_sync <= {sck_sync[TOP-1:0], sck_pin};
      sdi_sync <= {sdi_sync[TOP-1:0], sdi_pin};
      sck_prev <= sck_sync[TOP];
    end
  end

  assign sck_rise = sck_sync[TOP] & ~sck_prev;
  assign sck_fall = ~sck_sync[TOP] & sck_prev;
  assign sdi_s    = sdi_sync[TOP];

  always_comb begin
    shift_evt  = 1'b0;
    cnt_evt    = 1'b0;
    latch_open = 1'b1;
    unique case (src)
      SRC_PIN: begin
        cnt_evt    = sck_rise | sck_fall;
        shift_evt  = smp_fall ? sck_fall : sck_rise;
        latch_open = smp_fall ? sck_rise : sck_fall;
      end
      SRC_TMR: begin
        cnt_evt   = tmr_tick;
        shift_evt = tmr_tick;
      end
      SRC_SW: begin
        cnt_evt   = sw_strobe;
        shift_evt = sw_strobe;
      end
      default: ;
    endcase
  end

  AST_SHIFT_IMPLIES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |-> cnt_evt); // R5
  AST_PIN_EDGES_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_PIN) && shift_evt |-> !latch_open); // R6
endmodule

// File: rtl/ssp_shift_reg.sv
module ssp_shift_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              shift_evt,
  input  logic              sdi_s,
  input  logic              latch_open,
  output logic [DATA_W-1:0] dr,
  output logic              sdo
);
  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] d,
                                                 input logic b);
    return {d[MSB-1:0], b};
  endfunction

  logic latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr <= '0;
    end else if (wr_en) begin
      dr <= wdata;
    end else if (shift_evt) begin
      dr <= shift_in(dr, sdi_s);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (latch_open) begin
      latch_q <= dr[MSB];
    end
  end

  assign sdo = latch_open ? dr[MSB] : latch_q;

  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt && !wr_en |=> dr[MSB:1] == $past(dr[MSB-1:0])); // R3
  AST_DATA_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dr == $past(wdata)); // R9
  AST_SDO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_open && $past(!latch_open) |-> $stable(sdo)); // R6
endmodule

// File: rtl/ssp_bit_counter.sv
module ssp_bit_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  input  logic             cnt_evt,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_flag,
  output logic             wrap
);
  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] c);
    return {1'b0, c} + 1'b1;
  endfunction

  logic [CNT_W:0] cnt_plus;

  assign cnt_plus = bump(cnt);
  assign wrap     = cnt_evt & ~wr_en & cnt_plus[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_en) begin
      cnt <= wdata;
    end else if (cnt_evt) begin
      cnt <= cnt_plus[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
    end else if (wrap) begin
      ovf_flag <= 1'b1;
    end else if (flag_clr) begin
      ovf_flag <= 1'b0;
    end
  end

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_evt && !wr_en && (cnt != '1) |=> cnt > $past(cnt)); // R4
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_evt && !wr_en && (cnt == '1) |=> (cnt == '0) && ovf_flag); // R7
  AST_COUNT_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt == $past(wdata)); // R9
endmodule

// File: rtl/ser_shift_port.sv
module ser_shift_port
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              sck_pin,
  input  logic              sdi_pin,
  input  logic              tmr_tick,
  output logic              sdo_pin,
  output logic              irq
);
  localparam int CTRL_W = 4;

  ssp_src_e          ctl_src;
  logic              ctl_fall;
  logic              ctl_ien;
  logic              wr_data, wr_cnt, wr_ctrl;
  logic              flag_clr, sw_strobe;
  logic              sdi_s, shift_evt, cnt_evt, latch_open;
  logic [DATA_W-1:0] dr;
  logic [CNT_W-1:0]  cnt;
  logic              ovf_flag, wrap;

  assign wr_data   = host_wr && (host_addr == REG_DATA);
  assign wr_cnt    = host_wr && (host_addr == REG_COUNT);
  assign wr_ctrl   = host_wr && (host_addr == REG_CTRL);
  assign flag_clr  = host_wr && (host_addr == REG_STAT) && host_wdata[0];
  assign sw_strobe = wr_ctrl && host_wdata[CTRL_STROBE_BIT] && (ctl_src == SRC_SW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_src  <= SRC_OFF;
      ctl_fall <= 1'b0;
      ctl_ien  <= 1'b0;
    end else if (wr_ctrl) begin
      ctl_src  <= ssp_src_e'(host_wdata[1:0]);
      ctl_fall <= host_wdata[CTRL_FALL_BIT];
      ctl_ien  <= host_wdata[CTRL_IEN_BIT];
    end
  end

  ssp_event_gen #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_pin    (sck_pin),
    .sdi_pin    (sdi_pin),
    .tmr_tick   (tmr_tick),
    .sw_strobe  (sw_strobe),
    .src        (ctl_src),
    .smp_fall   (ctl_fall),
    .sdi_s      (sdi_s),
    .shift_evt  (shift_evt),
    .cnt_evt    (cnt_evt),
    .latch_open (latch_open)
  );

  ssp_shift_reg #(.DATA_W(DATA_W)) u_sreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_data),
    .wdata      (host_wdata),
    .shift_evt  (shift_evt),
    .sdi_s      (sdi_s),
    .latch_open (latch_open),
    .dr         (dr),
    .sdo        (sdo_pin)
  );

  ssp_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_cnt),
    .wdata    (host_wdata[CNT_W-1:0]),
    .cnt_evt  (cnt_evt),
    .flag_clr (flag_clr),
    .cnt      (cnt),
    .ovf_flag (ovf_flag),
    .wrap     (wrap)
  );

  assign irq = ovf_flag & ctl_ien;

  always_comb begin
    unique case (host_addr)
      REG_DATA:  host_rdata = dr;
      REG_COUNT: host_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt};
      REG_STAT:  host_rdata = {{(DATA_W-1){1'b0}}, ovf_flag};
      default:   host_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctl_ien, ctl_fall, ctl_src};
    endcase
  end

  AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && ctl_ien && !wr_ctrl |=> irq); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ien |-> !irq); // R8
endmodule

// File: tb/ser_shift_port_tb.sv
module ser_shift_port_tb;
  typedef struct {
    int         kind;   // 0 rdata, 1 sdo, 2 irq
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       sck_pin = 1'b0;
  logic       sdi_pin = 1'b0;
  logic       tmr_tick = 1'b0;
  logic       sdo_pin;
  logic       irq;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  ser_shift_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sck_pin(sck_pin),
    .sdi_pin(sdi_pin), .tmr_tick(tmr_tick), .sdo_pin(sdo_pin), .irq(irq)
  );

  // monitor: compares queued expectations between clock edges
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      act = (it.kind == 0) ? host_rdata : (it.kind == 1) ? {7'd0, sdo_pin} : {7'd0, irq};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [7:0] ref_shift(input logic [7:0] d, input logic b);
    return (d << 1) | {7'd0, b};
  endfunction

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    step(1);
    host_wr = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [1:0] a,
                             input logic [7:0] e, input string tag);
    item_t it;
    host_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    step(1);
  endtask

  task automatic tick();
    tmr_tick = 1'b1;
    step(1);
    tmr_tick = 1'b0;
  endtask

  task automatic sck_to(input logic v);
    sck_pin = v;
    step(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] m_dr;
    logic [7:0] pat;
    step(3);
    rst_n = 1'b1;
    step(1);

    // reset state
    expect_item(0, 2'd0, 8'h00, "R1 data");
    expect_item(0, 2'd1, 8'h00, "R1 count");
    expect_item(0, 2'd2, 8'h00, "R1 status");
    expect_item(0, 2'd3, 8'h00, "R1 control");
    expect_item(2, 2'd0, 8'h00, "R1 irq");
    expect_item(1, 2'd0, 8'h00, "R1 sdo");

    // register access
    wr(2'd0, 8'hA5);
    expect_item(0, 2'd0, 8'hA5, "R2 data readback");
    wr(2'd1, 8'hF9);
    expect_item(0, 2'd1, 8'h09, "R2 count upper bits");
    wr(2'd3, 8'h1E);
    expect_item(0, 2'd3, 8'h0E, "R2 control strobe reads 0");
    expect_item(0, 2'd0, 8'hA5, "R11 strobe without sw source");
    expect_item(0, 2'd1, 8'h09, "R11 count untouched");
    wr(2'd3, 8'h00);
    expect_item(1, 2'd0, 8'h01, "R6 sdo follows msb");

    // source off ignores ticks
    tick();
    expect_item(0, 2'd1, 8'h09, "R10 off source count");
    expect_item(0, 2'd0, 8'hA5, "R10 off source data");

    // software strobe source
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h81);
    sdi_pin = 1'b1;
    wr(2'd3, 8'h03);
    step(3);
    wr(2'd3, 8'h13);
    m_dr = ref_shift(8'h81, 1'b1);
    expect_item(0, 2'd0, m_dr, "R3 R11 first strobe shift");
    expect_item(0, 2'd1, 8'h01, "R4 strobe count");
    expect_item(1, 2'd0, {7'd0, m_dr[7]}, "R6 sdo after strobe");
    tick();
    expect_item(0, 2'd1, 8'h01, "R10 tick ignored in sw mode");
    for (int i = 0; i < 7; i++) begin
      sdi_pin = i[0];
      step(3);
      wr(2'd3, 8'h13);
      m_dr = ref_shift(m_dr, i[0]);
    end
    expect_item(0, 2'd0, m_dr, "R3 alternating bits");
    expect_item(0, 2'd1, 8'h08, "R4 eight strobes");

    // timer source, wrap and interrupt
    wr(2'd3, 8'h0A);
    wr(2'd1, 8'h0E);
    wr(2'd0, 8'h00);
    sdi_pin = 1'b1; step(3);
    tick();
    expect_item(0, 2'd1, 8'h0F, "R4 tick count");
    expect_item(0, 2'd2, 8'h00, "R7 no flag before wrap");
    sdi_pin = 1'b0; step(3);
    tick();
    expect_item(0, 2'd0, 8'h02, "R3 timer shift");
    expect_item(0, 2'd1, 8'h00, "R7 wrap to zero");
    expect_item(0, 2'd2, 8'h01, "R7 flag set");
    expect_item(2, 2'd0, 8'h01, "R8 irq raised");
    wr(2'd2, 8'h01);
    expect_item(0, 2'd2, 8'h00, "R7 write one clears");
    expect_item(2, 2'd0, 8'h00, "R8 irq drops");
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h0F);
    tick();
    expect_item(0, 2'd2, 8'h01, "R7 flag with irq disabled");
    expect_item(2, 2'd0, 8'h00, "R8 irq masked");
    wr(2'd2, 8'h01);

    // write precedence
    wr(2'd1, 8'h05);
    host_addr = 2'd1; host_wdata = 8'h0F; host_wr = 1'b1; tmr_tick = 1'b1;
    step(1);
    host_wr = 1'b0; tmr_tick = 1'b0;
    expect_item(0, 2'd1, 8'h0F, "R9 count write beats tick");
    expect_item(0, 2'd2, 8'h00, "R9 no wrap on written count");
    host_addr = 2'd0; host_wdata = 8'h3C; host_wr = 1'b1; tmr_tick = 1'b1;
    step(1);
    host_wr = 1'b0; tmr_tick = 1'b0;
    expect_item(0, 2'd0, 8'h3C, "R9 data write beats shift");
    expect_item(0, 2'd2, 8'h01, "R7 counter still wrapped");
    wr(2'd1, 8'h0F);
    host_addr = 2'd2; host_wdata = 8'h01; host_wr = 1'b1; tmr_tick = 1'b1;
    step(1);
    host_wr = 1'b0; tmr_tick = 1'b0;
    expect_item(0, 2'd2, 8'h01, "R7 set wins over clear");
    wr(2'd2, 8'h01);

    // pin source, sample on rising edge
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hC3);
    expect_item(1, 2'd0, 8'h00, "R6 sdo held after load");
    pat = 8'h5A;
    sdi_pin = pat[7]; step(3);
    sck_to(1'b1);
    expect_item(0, 2'd0, 8'h86, "R5 rising edge shifts");
    expect_item(1, 2'd0, 8'h00, "R6 sdo held at sample edge");
    expect_item(0, 2'd1, 8'h01, "R4 rising edge counted");
    sck_to(1'b0);
    expect_item(1, 2'd0, 8'h01, "R6 sdo updates on opposite edge");
    expect_item(0, 2'd0, 8'h86, "R5 falling edge no shift");
    expect_item(0, 2'd1, 8'h02, "R4 falling edge counted");
    for (int b = 6; b >= 0; b--) begin
      sdi_pin = pat[b]; step(3);
      sck_to(1'b1);
      sck_to(1'b0);
    end
    expect_item(0, 2'd0, 8'h5A, "R3 pin byte received");
    expect_item(0, 2'd1, 8'h00, "R4 sixteen edges wrap");
    expect_item(0, 2'd2, 8'h01, "R7 pin byte overflow");
    wr(2'd2, 8'h01);

    // pin source, sample on falling edge
    wr(2'd3, 8'h05);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    sdi_pin = 1'b1; step(3);
    sck_to(1'b1);
    expect_item(0, 2'd0, 8'h00, "R5 rising edge idle in fall mode");
    expect_item(0, 2'd1, 8'h01, "R5 rising edge counted");
    sck_to(1'b0);
    expect_item(0, 2'd0, 8'h01, "R5 falling edge shifts");
    expect_item(0, 2'd1, 8'h02, "R5 falling edge counted");

    step(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule